// File: doc/BRIEF.md
# External I/O Bank Bus Controller

This block connects an internal single-word request port to an asynchronous parallel bus that serves two external I/O banks. The bank and one of its two chip selects are picked by fixed address bits. For each bank, the block reads the bus width and three timing fields from its configuration inputs. It then runs the access as one or more bus cycles, each made of an address setup phase, a read or write strobe phase and a hold phase.

A 32-bit internal word is split into two half-word cycles on a 16-bit bank or four byte cycles on an 8-bit bank. An external active-low wait pin can stretch the strobe once the programmed minimum has elapsed. Read data is collected beat by beat. The requester sees a single ready pulse, with an error flag for addresses outside the I/O window.

A request is accepted on any rising clock edge where the block is idle and `reqValid` is high. The requester drops `reqValid` after one cycle and waits for `rspReady`. The configuration inputs must stay stable while an access is in progress.

Top module: `iobank_bus_ctrl`

## Requirements
- R1: An address is mapped when bits [31:26] equal 6'b001100. Bit 25 selects the bank and bit 24 selects the chip select within it. During a mapped access, exactly `busCsN[2*bank+cs]` is low, and at most one chip select is ever low.
- R2: An unmapped request produces `rspReady` and `rspErr` together in the cycle after acceptance. No chip select or strobe goes low for that request.
- R3: Each bus cycle consists of three phases. The setup phase lasts setup+1 clocks, with the chip select low and both strobes high. The strobe phase lasts at least strobe+1 clocks. The hold phase lasts hold clocks, with the strobe high and the chip select still low. Each field is 4 bits per bank, with bank b in bits [4b+3:4b].
- R4: In the last programmed strobe clock and after it, the strobe phase goes on while `busWaitN` is low. It ends at the first clock edge that samples `busWaitN` high. A low `busWaitN` before the minimum has elapsed does not change the access length.
- R5: A bank whose `cfgWide16` bit is 1 is accessed in two 16-bit beats, low half first. `busAddr` is the word address with low bits 2'b00 and then 2'b10. Data uses `busDout[15:0]`. `busBeN` is the inverted pair of request byte enables for that half.
- R6: A bank whose `cfgWide16` bit is 0 is accessed in four byte beats, lowest byte first, at byte addresses +0 to +3. Data uses `busDout[7:0]` with `busDout[15:8]` at zero. `busBeN[1]` stays high and `busBeN[0]` is the inverted enable of that byte.
- R7: Read data is sampled from `busDin` at the clock edge that ends each strobe phase: the full 16 bits on a wide bank, bits [7:0] on a narrow bank. The assembled word appears on `rspRdata` with the ready pulse.
- R8: `rspReady` is a one-clock pulse. It comes in the clock after the last hold phase, or after the last strobe phase if hold is zero. `rspErr` is low for mapped accesses, and all chip selects are high while `rspReady` is high.
- R9: `busDoe` is high in every setup, strobe and hold clock of a write and low otherwise. `busWrN` goes low only for writes and `busRdN` only for reads, never both at once.
- R10: During reset and while idle, all chip selects and both strobes are high, and `busDoe` and `rspReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, accepted when idle |
| reqAddr | input | 32 | Request byte address (word aligned) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, bit i for byte i |
| rspReady | output | 1 | One-clock completion pulse |
| rspErr | output | 1 | Error flag, valid with rspReady |
| rspRdata | output | 32 | Read data, valid with rspReady |
| cfgWide16 | input | 2 | Per-bank bus width, 1 = 16-bit |
| cfgSetup | input | 8 | Per-bank setup field, 4 bits each |
| cfgStrobe | input | 8 | Per-bank strobe field, 4 bits each |
| cfgHold | input | 8 | Per-bank hold field, 4 bits each |
| busCsN | output | 4 | Active-low chip selects, index 2*bank+cs |
| busAddr | output | 24 | Bus byte address |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busBeN | output | 2 | Active-low byte lane enables |
| busDoe | output | 1 | Data output enable for the pad |
| busDout | output | 16 | Data driven to the bus |
| busDin | input | 16 | Data from the bus |
| busWaitN | input | 1 | Active-low wait from the device |

## Verification
The hardest case to reach is the edge of the wait window: the pin held low exactly up to the programmed strobe minimum, or held low past it on some beats of a split access but not on others. The bench uses a device model that counts strobe clocks per beat and holds the wait pin low for a chosen number of them. It sweeps that count below, at and beyond the strobe field on both bus widths. It also mixes zero and maximum setup and hold values, so that beat boundaries with no hold phase are exercised.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RESP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // capture a new request
    logic       capture;  // sample bus read data this cycle
    logic [1:0] beat;     // current beat index
    logic       wide;     // bank is 16-bit
  } dpStrobe_t;

endpackage

// File: rtl/iobus_datapath.sv
module iobus_datapath
  import iobus_pkg::*;
#(
  parameter int BUS_AW = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BUS_AW-1:2] reqWordAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  input  logic [15:0]       busDin,
  output logic [BUS_AW-1:0] busAddr,
  output logic [15:0]       busDout,
  output logic [1:0]        busBeN,
  output logic [31:0]       rspRdata
);

  logic [BUS_AW-1:2] addrQ;
  logic [31:0]       wdataQ;
  logic [3:0]        beQ;
  logic [31:0]       rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
    end else if (stb.load) begin
      addrQ  <= reqWordAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      rdataQ <= '0;
    end else if (stb.capture) begin
      if (stb.wide) rdataQ[16*stb.beat[0] +: 16] <= busDin;
      else          rdataQ[8*stb.beat +: 8]      <= busDin[7:0];
    end
  end

  always_comb begin
    if (stb.wide) begin
      busAddr = {addrQ, stb.beat[0], 1'b0};
      busDout = wdataQ[16*stb.beat[0] +: 16];
      busBeN  = ~beQ[2*stb.beat[0] +: 2];
    end else begin
      busAddr = {addrQ, stb.beat};
      busDout = {8'h00, wdataQ[8*stb.beat +: 8]};
      busBeN  = {1'b1, ~beQ[stb.beat]};
    end
  end

  assign rspRdata = rdataQ;

endmodule

// File: rtl/iobus_ctrl.sv
module iobus_ctrl
  import iobus_pkg::*;
#(
  parameter int              NUM_BANKS = 2,
  parameter int              CNT_W     = 4,
  parameter int              TAG_W     = 6,
  parameter logic [TAG_W-1:0] IO_TAG   = 6'b001100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [TAG_W-1:0]           reqTag,
  input  logic                       reqBank,
  input  logic                       reqCs,
  input  logic                       reqWrite,
  input  logic [NUM_BANKS-1:0]       cfgWide16,
  input  logic [NUM_BANKS*CNT_W-1:0] cfgSetup,
  input  logic [NUM_BANKS*CNT_W-1:0] cfgStrobe,
  input  logic [NUM_BANKS*CNT_W-1:0] cfgHold,
  input  logic                       busWaitN,
  output logic [2*NUM_BANKS-1:0]     busCsN,
  output logic                       busRdN,
  output logic                       busWrN,
  output logic                       busDoe,
  output logic                       rspReady,
  output logic                       rspErr,
  output dpStrobe_t                  stb
);

  localparam int NUM_CS = 2 * NUM_BANKS;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       beat;
  logic             bankQ, csQ, writeQ, errQ;

  logic             wide, lastBeat, active, strobeDone, beatEnd;
  logic [CNT_W-1:0] tSetup, tStrobe, tHold;

  assign wide    = cfgWide16[bankQ];
  assign tSetup  = cfgSetup[bankQ*CNT_W +: CNT_W];
  assign tStrobe = cfgStrobe[bankQ*CNT_W +: CNT_W];
  assign tHold   = cfgHold[bankQ*CNT_W +: CNT_W];

  assign lastBeat   = wide ? (beat == 2'd1) : (beat == 2'd3);
  assign active     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  // strobe ends once the minimum is met and the device releases wait
  assign strobeDone = (phase == PH_STROBE) && (cnt >= tStrobe) && busWaitN;
  assign beatEnd    = (strobeDone && (tHold == '0)) ||
                      ((phase == PH_HOLD) && (cnt == tHold - CNT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      beat   <= '0;
      bankQ  <= 1'b0;
      csQ    <= 1'b0;
      writeQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (reqValid) begin
          bankQ  <= reqBank;
          csQ    <= reqCs;
          writeQ <= reqWrite;
          beat   <= '0;
          cnt    <= '0;
          errQ   <= (reqTag != IO_TAG);
          phase  <= (reqTag == IO_TAG) ? PH_SETUP : PH_RESP;
        end
        PH_SETUP: begin
          if (cnt == tSetup) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
        PH_STROBE, PH_HOLD: begin
          if (beatEnd) begin
            cnt <= '0;
            if (lastBeat) phase <= PH_RESP;
            else begin
              phase <= PH_SETUP;
              beat  <= beat + 2'd1;
            end
          end else if (strobeDone) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else if (phase == PH_HOLD || cnt < tStrobe) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_RESP: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign busCsN[i] = !(active && ({bankQ, csQ} == i[1:0]));
    end
  endgenerate

  assign busRdN   = !((phase == PH_STROBE) && !writeQ);
  assign busWrN   = !((phase == PH_STROBE) && writeQ);
  assign busDoe   = active && writeQ;
  assign rspReady = (phase == PH_RESP);
  assign rspErr   = (phase == PH_RESP) && errQ;

  assign stb.load    = (phase == PH_IDLE) && reqValid;
  assign stb.capture = strobeDone && !writeQ;
  assign stb.beat    = beat;
  assign stb.wide    = wide;

endmodule

// File: rtl/iobank_bus_ctrl.sv
module iobank_bus_ctrl
  import iobus_pkg::*;
#(
  parameter int               BUS_AW = 24,
  parameter int               CNT_W  = 4,
  parameter logic [5:0]       IO_TAG = 6'b001100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [31:0]         reqAddr,
  input  logic                reqWrite,
  input  logic [31:0]         reqWdata,
  input  logic [3:0]          reqBe,
  output logic                rspReady,
  output logic                rspErr,
  output logic [31:0]         rspRdata,
  input  logic [1:0]          cfgWide16,
  input  logic [2*CNT_W-1:0]  cfgSetup,
  input  logic [2*CNT_W-1:0]  cfgStrobe,
  input  logic [2*CNT_W-1:0]  cfgHold,
  output logic [3:0]          busCsN,
  output logic [BUS_AW-1:0]   busAddr,
  output logic                busRdN,
  output logic                busWrN,
  output logic [1:0]          busBeN,
  output logic                busDoe,
  output logic [15:0]         busDout,
  input  logic [15:0]         busDin,
  input  logic                busWaitN
);

  localparam int TAG_W = 6;

  dpStrobe_t stb;
  logic      unusedAddrLsb;
  assign unusedAddrLsb = ^reqAddr[1:0];

  iobus_ctrl #(
    .NUM_BANKS(2), .CNT_W(CNT_W), .TAG_W(TAG_W), .IO_TAG(IO_TAG)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqTag   (reqAddr[31 -: TAG_W]),
    .reqBank  (reqAddr[25]),
    .reqCs    (reqAddr[24]),
    .reqWrite (reqWrite),
    .cfgWide16(cfgWide16),
    .cfgSetup (cfgSetup),
    .cfgStrobe(cfgStrobe),
    .cfgHold  (cfgHold),
    .busWaitN (busWaitN),
    .busCsN   (busCsN),
    .busRdN   (busRdN),
    .busWrN   (busWrN),
    .busDoe   (busDoe),
    .rspReady (rspReady),
    .rspErr   (rspErr),
    .stb      (stb)
  );

  iobus_datapath #(.BUS_AW(BUS_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqWordAddr(reqAddr[BUS_AW-1:2]),
    .reqWdata   (reqWdata),
    .reqBe      (reqBe),
    .busDin     (busDin),
    .busAddr    (busAddr),
    .busDout    (busDout),
    .busBeN     (busBeN),
    .rspRdata   (rspRdata)
  );

endmodule

// File: rtl/iobus_checker.sv
module iobus_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] busCsN,
  input logic       busRdN,
  input logic       busWrN,
  input logic       busWaitN,
  input logic       busDoe,
  input logic       rspReady,
  input logic       rspErr
);

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~busCsN) <= 1);

  assert_err_no_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspReady && rspErr) |-> ((&busCsN) && $past(&busCsN) && $past(busRdN && busWrN)));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN || !busWrN) |-> !(&busCsN));

  assert_wait_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN && !busWaitN) |=> !busRdN);

  assert_wait_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrN && !busWaitN) |=> !busWrN);

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);

  assert_ready_idle_bus_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (&busCsN));

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN));

  assert_no_doe_on_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busDoe);

endmodule

bind iobank_bus_ctrl iobus_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busCsN  (busCsN),
  .busRdN  (busRdN),
  .busWrN  (busWrN),
  .busWaitN(busWaitN),
  .busDoe  (busDoe),
  .rspReady(rspReady),
  .rspErr  (rspErr)
);

// File: tb/iobank_bus_ctrl_tb.sv
module iobank_bus_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        rspReady, rspErr;
  logic [31:0] rspRdata;
  logic [1:0]  cfgWide16 = 2'b01;
  logic [7:0]  cfgSetup = '0, cfgStrobe = '0, cfgHold = '0;
  logic [3:0]  busCsN;
  logic [23:0] busAddr;
  logic        busRdN, busWrN, busDoe;
  logic [1:0]  busBeN;
  logic [15:0] busDout;
  logic [15:0] busDin = '0;
  logic        busWaitN = 1'b1;

  int checks = 0;
  int errors = 0;
  int waitLen = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iobank_bus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspReady(rspReady), .rspErr(rspErr), .rspRdata(rspRdata),
    .cfgWide16(cfgWide16), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .busCsN(busCsN), .busAddr(busAddr), .busRdN(busRdN),
    .busWrN(busWrN), .busBeN(busBeN), .busDoe(busDoe), .busDout(busDout),
    .busDin(busDin), .busWaitN(busWaitN)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] devData(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h33};
  endfunction

  // device model: read data from address, wait held low for waitLen strobe clocks
  int waitLeft = 0;
  always @(negedge clk) begin
    busDin <= devData(busAddr);
    if (!busRdN || !busWrN) begin
      busWaitN <= (waitLeft == 0);
      if (waitLeft > 0) waitLeft = waitLeft - 1;
    end else begin
      busWaitN <= 1'b1;
      waitLeft = waitLen;
    end
  end

  // behavioural reference model
  int          mPh = 0, mCnt = 0, mBeat = 0, mBank = 0, mCs = 0;
  bit          mWr = 0, mErr = 0;
  logic [31:0] mAddr = '0, mWdata = '0, mRdata = '0;
  logic [3:0]  mBe = '0;

  function automatic int fld(input logic [7:0] v, input int b);
    return (v >> (4*b)) & 15;
  endfunction

  function automatic bit mWide();
    return cfgWide16[mBank];
  endfunction

  task automatic nextBeat();
    if (mBeat == (mWide() ? 1 : 3)) mPh = 4;
    else begin
      mBeat = mBeat + 1;
      mPh = 1;
      mCnt = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0;
    end else begin
      case (mPh)
        0: if (reqValid) begin
          mAddr = reqAddr; mWr = reqWrite; mWdata = reqWdata; mBe = reqBe;
          mBank = reqAddr[25]; mCs = reqAddr[24];
          mBeat = 0; mCnt = 0; mRdata = '0;
          if (reqAddr[31:26] == 6'b001100) begin mPh = 1; mErr = 0; end
          else begin mPh = 4; mErr = 1; end
        end
        1: if (mCnt == fld(cfgSetup, mBank)) begin mPh = 2; mCnt = 0; end
           else mCnt = mCnt + 1;
        2: if (mCnt >= fld(cfgStrobe, mBank) && busWaitN) begin
          if (mWide()) mRdata = mRdata | (32'(busDin) << (16*mBeat));
          else         mRdata = mRdata | (32'(busDin[7:0]) << (8*mBeat));
          if (fld(cfgHold, mBank) > 0) begin mPh = 3; mCnt = 0; end
          else nextBeat();
        end else mCnt = mCnt + 1;
        3: begin
          mCnt = mCnt + 1;
          if (mCnt == fld(cfgHold, mBank)) nextBeat();
        end
        default: mPh = 0;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rstN) begin
      chk(busCsN == 4'hF && busRdN && busWrN && !busDoe && !rspReady, "R10",
          {busCsN, busRdN, busWrN, busDoe, rspReady}, {4'hF, 4'b1100});
    end else if (!done) begin
      bit          act;
      logic [3:0]  eCs;
      logic [23:0] eAddr;
      logic [15:0] eDout;
      logic [1:0]  eBe;
      act = (mPh >= 1 && mPh <= 3);
      eCs = act ? ~(4'b1 << (mBank*2 + mCs)) : 4'hF;
      chk(busCsN == eCs, "R1", 32'(busCsN), 32'(eCs));
      chk(busRdN == !(mPh == 2 && !mWr) && busWrN == !(mPh == 2 && mWr), "R3",
          {busRdN, busWrN}, {!(mPh == 2 && !mWr), !(mPh == 2 && mWr)});
      chk(busDoe == (act && mWr), "R9", 32'(busDoe), 32'(act && mWr));
      if (act) begin
        if (mWide()) begin
          eAddr = (mAddr[23:0] & ~24'h3) + 24'(2*mBeat);
          eDout = 16'(mWdata >> (16*mBeat));
          eBe   = ~2'(mBe >> (2*mBeat));
          chk(busAddr == eAddr && busBeN == eBe, "R5", {busAddr, 6'd0, busBeN}, {eAddr, 6'd0, eBe});
          if (mWr) chk(busDout == eDout, "R5", 32'(busDout), 32'(eDout));
        end else begin
          eAddr = (mAddr[23:0] & ~24'h3) + 24'(mBeat);
          eDout = {8'h00, 8'(mWdata >> (8*mBeat))};
          eBe   = {1'b1, ~mBe[mBeat]};
          chk(busAddr == eAddr && busBeN == eBe, "R6", {busAddr, 6'd0, busBeN}, {eAddr, 6'd0, eBe});
          if (mWr) chk(busDout == eDout, "R6", 32'(busDout), 32'(eDout));
        end
      end
      chk(rspReady == (mPh == 4), "R8", 32'(rspReady), 32'(mPh == 4));
      if (mPh == 4) begin
        chk(rspErr == mErr, "R2", 32'(rspErr), 32'(mErr));
        if (!mErr && !mWr) chk(rspRdata == mRdata, "R7", rspRdata, mRdata);
      end
    end
  end

  // independent end-to-end expectations
  function automatic int expCycles(input logic [31:0] a, input int w);
    int b, beats, st;
    if (a[31:26] != 6'b001100) return 1;
    b = a[25];
    beats = cfgWide16[b] ? 2 : 4;
    st = (fld(cfgStrobe, b) > w) ? fld(cfgStrobe, b) : w;
    return beats * (fld(cfgSetup, b) + 1 + st + 1 + fld(cfgHold, b)) + 1;
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] a);
    logic [23:0] base;
    base = a[23:0] & ~24'h3;
    if (cfgWide16[a[25]]) return {devData(base + 24'd2), devData(base)};
    return {devData(base + 24'd3)[7:0], devData(base + 24'd2)[7:0],
            devData(base + 24'd1)[7:0], devData(base)[7:0]};
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                        input logic [3:0] be, input int w, input string tag);
    int n;
    int expN;
    waitLen = w;
    expN = expCycles(a, w);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!rspReady && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n == expN, tag, 32'(n), 32'(expN));
    if (a[31:26] != 6'b001100) chk(rspErr == 1'b1, "R2", 32'(rspErr), 32'd1);
    else begin
      chk(rspErr == 1'b0, "R8", 32'(rspErr), 32'd0);
      if (!wr) chk(rspRdata == expRead(a), "R7", rspRdata, expRead(a));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // bank0 16-bit, bank1 8-bit
    cfgWide16 = 2'b01;
    cfgSetup = 8'h01; cfgStrobe = 8'h02; cfgHold = 8'h01;
    access(32'h3000_0120, 1, 32'hCAFE_1234, 4'hF, 0, "R3");   // R5 write
    access(32'h3100_0040, 0, '0, 4'h3, 0, "R3");              // R5 read, cs1
    cfgSetup = 8'h00; cfgStrobe = 8'h00; cfgHold = 8'h00;
    access(32'h3200_0A08, 0, '0, 4'hF, 0, "R3");              // R6 read, zero timing
    access(32'h3300_0FFC, 1, 32'hA1B2_C3D4, 4'b0101, 0, "R6");
    cfgStrobe = 8'h11;
    access(32'h3000_0200, 0, '0, 4'hF, 5, "R4");              // wait stretches
    cfgStrobe = 8'h33;
    access(32'h3200_0300, 0, '0, 4'hF, 2, "R4");              // wait below minimum
    access(32'h3200_0304, 1, 32'h0F0F_5555, 4'hE, 3, "R4");   // wait at minimum
    access(32'h4000_0000, 0, '0, 4'hF, 0, "R2");
    access(32'h3400_0010, 1, 32'h1111_2222, 4'hF, 0, "R2");
    cfgWide16 = 2'b10;
    cfgSetup = 8'hF0; cfgStrobe = 8'hF0; cfgHold = 8'hF0;     // bank1 max timing
    access(32'h3300_0124, 0, '0, 4'b1100, 4, "R3");
    access(32'h3000_0128, 1, 32'h7788_99AA, 4'b1001, 1, "R6");
    cfgHold = 8'h0F;
    access(32'h3100_0130, 0, '0, 4'hF, 20, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule